// File: doc/BRIEF.md
# Single-wire Manchester trace message transmitter

This block sends trace messages off chip on one output wire. Upstream logic hands it a stream of bytes with a valid/ready handshake and marks the final byte of each message with an end-of-message flag. The bytes go into a small buffer. The encoder then sends each message as one frame: a start bit, every data bit of the message, and a stop bit. Each bit is split into two phases, and the pair of line levels in those two phases identifies the bit.

Phase timing comes from the system clock divided by a programmable value plus one. A bit therefore lasts two divided periods. A single enable input gates the whole block. While the enable is low, the line rests low, no input is accepted, and anything that was buffered or in flight is discarded. A status output reports when nothing is buffered and the line is idle.

Top module: `mtrace_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `trc_o` is low and `empty_o` is high. While `enable_i` is low, `byte_ready_o` is low.
- R2: Every frame opens with a start bit, sent as a high phase followed by a low phase.
- R3: Each data bit takes two phases. A 0 is sent as low then high, and a 1 as high then low.
- R4: Inside a frame, each byte is sent bit 0 first, and bytes are sent in the order they were accepted.
- R5: The byte accepted with `byte_last_i` high is the last byte of its frame. It is followed by one stop bit, sent as two low phases. A whole message has exactly one start bit and one stop bit.
- R6: Every phase lasts `divider_i` + 1 clock cycles, and `trc_o` changes only at phase boundaries.
- R7: If `enable_i` is low at a clock edge, `trc_o` is low after that edge. Inputs offered while disabled are not taken. Dropping the enable discards buffered bytes and any frame in progress, so nothing from them is sent after the block is re-enabled.
- R8: If another complete message is already buffered when a stop bit ends, the next start bit begins in the very next phase.
- R9: `empty_o` is high exactly when the buffer holds no byte and the encoder is idle. It is low while a frame is being sent.
- R10: The buffer holds `DEPTH` bytes, and `byte_ready_o` is low when it is full. A frame starts once a complete message is buffered, or once the buffer is full. This lets a message longer than `DEPTH` bytes go out in a single frame while the source keeps refilling the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Block enable; low holds the line idle and flushes state |
| divider_i | input | DIV_W | Phase length is this value plus one clock cycles |
| byte_i | input | BYTE_W | Message byte |
| byte_valid_i | input | 1 | `byte_i` is offered |
| byte_last_i | input | 1 | The offered byte ends its message |
| byte_ready_o | output | 1 | A byte is taken on any edge where valid and ready are both high |
| trc_o | output | 1 | Manchester-coded trace line |
| empty_o | output | 1 | No byte is buffered and the line is idle |

## Verification
`trc_o` is a register. It moves one clock edge after a phase boundary, and each new level then holds for `divider_i` + 1 cycles. The first start phase appears at the first phase boundary after the message's closing byte has been accepted.

For the frame checks, the bench waits until it sees the line go high. From that point it samples on falling clock edges, stepping exactly `divider_i` + 1 cycles per phase, so a wrong phase length shifts the samples onto the wrong levels. It compares each sample with a phase list built from the message bytes, and the list includes two idle phases after the stop bit.

Enable, ready and empty effects are due right after the next rising edge. The bench reads them at the falling edge that follows the stimulus.

// File: rtl/mtrace_pkg.sv
`timescale 1ns/1ps
package mtrace_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START1,
    ST_START2,
    ST_D1,
    ST_D2,
    ST_STOP1,
    ST_STOP2
  } ph_state_e;
endpackage

// File: rtl/mtrace_timebase.sv
`timescale 1ns/1ps
module mtrace_timebase #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  // A phase boundary falls on the last cycle of each divided period.
  // Using >= recovers at once if the divider is lowered while running.
  assign tick_o = en && (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mtrace_fifo.sv
`timescale 1ns/1ps
module mtrace_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);

  // Storage: write port and registered read port, no reset (RAM-friendly).
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else begin
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full_o);

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty_o);
endmodule

// File: rtl/mtrace_encoder.sv
`timescale 1ns/1ps
module mtrace_encoder
  import mtrace_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              msg_rdy,
  input  logic              buf_empty,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              rd_last,
  output logic              pop_o,
  output logic              load_o,
  output logic              line_o,
  output logic              idle_o
);
  localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(BYTE_W - 1);

  ph_state_e         st;
  logic [BYTE_W-1:0] sh;
  logic [IW-1:0]     idx;
  logic              last_q;
  logic              have_next;
  logic              at_last_bit;

  assign at_last_bit = (idx == LAST_IDX);
  assign idle_o      = (st == ST_IDLE);

  // The next byte is fetched one phase early, so the registered buffer
  // read has settled even when every cycle is a phase boundary.
  assign pop_o = tick && ((st == ST_START1) ||
                          (st == ST_D1 && at_last_bit && !last_q && !buf_empty));
  assign load_o = tick && ((st == ST_START2) ||
                           (st == ST_D2 && at_last_bit && !last_q && have_next));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st        <= ST_IDLE;
      line_o    <= 1'b0;
      sh        <= '0;
      idx       <= '0;
      last_q    <= 1'b0;
      have_next <= 1'b0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          if (msg_rdy) begin
            st     <= ST_START1;
            line_o <= 1'b1;
          end
        end
        ST_START1: begin
          st        <= ST_START2;
          line_o    <= 1'b0;
          have_next <= 1'b1;
        end
        ST_START2: begin
          st        <= ST_D1;
          sh        <= rd_data;
          last_q    <= rd_last;
          idx       <= '0;
          have_next <= 1'b0;
          line_o    <= rd_data[0];
        end
        ST_D1: begin
          st     <= ST_D2;
          line_o <= ~sh[idx];
          if (pop_o) have_next <= 1'b1;
        end
        ST_D2: begin
          if (!at_last_bit) begin
            st     <= ST_D1;
            idx    <= idx + 1'b1;
            line_o <= sh[idx + 1'b1];
          end else if (load_o) begin
            st        <= ST_D1;
            sh        <= rd_data;
            last_q    <= rd_last;
            idx       <= '0;
            have_next <= 1'b0;
            line_o    <= rd_data[0];
          end else begin
            // Closing byte sent, or the source ran dry: end the frame.
            st     <= ST_STOP1;
            line_o <= 1'b0;
          end
        end
        ST_STOP1: begin
          st     <= ST_STOP2;
          line_o <= 1'b0;
        end
        ST_STOP2: begin
          if (msg_rdy) begin
            st     <= ST_START1;
            line_o <= 1'b1;
          end else begin
            st     <= ST_IDLE;
            line_o <= 1'b0;
          end
        end
        default: begin
          st     <= ST_IDLE;
          line_o <= 1'b0;
        end
      endcase
    end
  end

  assert_idle_line_low_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !line_o);

  assert_start_phase_high_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START1) |-> line_o);

  assert_bit_halves_differ_R3: assert property (@(posedge clk) disable iff (rst)
    (en && tick && st == ST_D1) |=> (line_o != $past(line_o)));

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(line_o));

  assert_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !line_o);
endmodule

// File: rtl/mtrace_tx.sv
`timescale 1ns/1ps
module mtrace_tx #(
  parameter int DIV_W  = 16,
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [DIV_W-1:0]  divider_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic              trc_o,
  output logic              empty_o
);
  localparam int ENT_W = BYTE_W + 1;
  localparam int MC_W  = $clog2(DEPTH + 1);

  logic             tick;
  logic             wr, pop, load;
  logic             buf_full, buf_empty;
  logic [ENT_W-1:0] rd_ent;
  logic [MC_W-1:0]  msg_cnt;
  logic             msg_rdy;
  logic             enc_idle;

  assign byte_ready_o = enable_i && !buf_full;
  assign wr           = byte_valid_i && byte_ready_o;
  assign msg_rdy      = (msg_cnt != '0) || buf_full;
  assign empty_o      = buf_empty && enc_idle;

  // Number of complete messages held in the buffer.
  always_ff @(posedge clk) begin
    if (rst || !enable_i) msg_cnt <= '0;
    else begin
      case ({wr && byte_last_i, load && rd_ent[BYTE_W]})
        2'b10:   msg_cnt <= msg_cnt + 1'b1;
        2'b01:   msg_cnt <= msg_cnt - 1'b1;
        default: msg_cnt <= msg_cnt;
      endcase
    end
  end

  mtrace_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .en     (enable_i),
    .div    (divider_i),
    .tick_o (tick)
  );

  mtrace_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clr     (!enable_i),
    .wr_en   (wr),
    .wr_data ({byte_last_i, byte_i}),
    .rd_en   (pop),
    .rd_data (rd_ent),
    .full_o  (buf_full),
    .empty_o (buf_empty)
  );

  mtrace_encoder #(.BYTE_W(BYTE_W)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .en        (enable_i),
    .tick      (tick),
    .msg_rdy   (msg_rdy),
    .buf_empty (buf_empty),
    .rd_data   (rd_ent[BYTE_W-1:0]),
    .rd_last   (rd_ent[BYTE_W]),
    .pop_o     (pop),
    .load_o    (load),
    .line_o    (trc_o),
    .idle_o    (enc_idle)
  );
endmodule

// File: tb/mtrace_tx_tb.sv
`timescale 1ns/1ps
module mtrace_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] divider = '0;
  logic [7:0]  byte_d = '0;
  logic        bvalid = 1'b0;
  logic        blast = 1'b0;
  logic        bready, trc, empty;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mtrace_tx u_dut (
    .clk          (clk),
    .rst          (rst),
    .enable_i     (enable),
    .divider_i    (divider),
    .byte_i       (byte_d),
    .byte_valid_i (bvalid),
    .byte_last_i  (blast),
    .byte_ready_o (bready),
    .trc_o        (trc),
    .empty_o      (empty)
  );

  typedef struct packed {
    logic [7:0]  div;
    logic [2:0]  len;
    logic [31:0] bytes;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd0, 3'd1, 32'h000000A5},
    '{8'd1, 3'd2, 32'h0000813C},
    '{8'd3, 3'd4, 32'h12345678},
    '{8'd2, 3'd3, 32'h00FF55AA},
    '{8'd5, 3'd1, 32'h00000000},
    '{8'd0, 3'd4, 32'hFFFFFFFF}
  };

  bit exp_ph [0:2047];
  int n_exp;
  int errs, first_bad;
  bit emp0, tmo;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_phase(input bit v);
    exp_ph[n_exp] = v;
    n_exp++;
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      add_phase(b[i]);
      add_phase(!b[i]);
    end
  endtask

  task automatic add_start();
    add_phase(1'b1); add_phase(1'b0);
  endtask

  task automatic add_stop();
    add_phase(1'b0); add_phase(1'b0);
  endtask

  task automatic push(input logic [7:0] d, input bit l);
    @(negedge clk);
    byte_d = d; blast = l; bvalid = 1'b1;
    while (!bready) @(negedge clk);
    @(posedge clk);
    #1;
    bvalid = 1'b0; blast = 1'b0;
  endtask

  task automatic configure(input int div);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    divider = div[15:0];
    enable = 1'b1;
  endtask

  // Waits for the start phase, then samples one point per phase.
  task automatic capture(input int div, output int e, output int fb,
                         output bit emp_start, output bit timed_out);
    int w = 0;
    e = 0; fb = -1; emp_start = 1'b1; timed_out = 1'b0;
    while (trc !== 1'b1 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 20000) begin
      timed_out = 1'b1;
      e = 1;
      return;
    end
    emp_start = empty;
    for (int k = 0; k < n_exp; k++) begin
      if (trc !== exp_ph[k]) begin
        e++;
        if (fb < 0) fb = k;
      end
      repeat (div + 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(trc == 1'b0, "R1 line after reset", trc, 0);
    check(empty == 1'b1, "R1 empty after reset", empty, 1);
    check(bready == 1'b0, "R1 ready while disabled", bready, 0);

    // R7: input offered while disabled is not taken
    bad = 0;
    byte_d = 8'hFF; blast = 1'b1; bvalid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bready !== 1'b0) bad++;
    end
    bvalid = 1'b0; blast = 1'b0;
    check(bad == 0, "R7 ready stays low while disabled", bad, 0);
    divider = 16'd0; enable = 1'b1;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (trc !== 1'b0 || empty !== 1'b1) bad++;
    end
    check(bad == 0, "R7 nothing sent from disabled offers", bad, 0);

    // Table of single-message frames
    for (int v = 0; v < 6; v++) begin
      configure(int'(VECS[v].div));
      n_exp = 0;
      add_start();
      for (int b = 0; b < int'(VECS[v].len); b++) add_byte(VECS[v].bytes[8*b +: 8]);
      add_stop();
      add_phase(1'b0); add_phase(1'b0);
      fork
        begin
          for (int b = 0; b < int'(VECS[v].len); b++)
            push(VECS[v].bytes[8*b +: 8], b == int'(VECS[v].len) - 1);
        end
        capture(int'(VECS[v].div), errs, first_bad, emp0, tmo);
      join
      if (errs != 0) $display("  vector %0d first bad phase %0d", v, first_bad);
      check(!tmo && errs == 0, "R2 R3 R4 R5 R6 frame phases", errs, 0);
      check(emp0 == 1'b0, "R9 empty low during frame", emp0, 0);
      check(empty == 1'b1 && trc == 1'b0, "R9 R1 idle after frame", empty, 1);
    end

    // R8: two messages back to back
    configure(2);
    n_exp = 0;
    add_start(); add_byte(8'h96); add_byte(8'h01); add_stop();
    add_start(); add_byte(8'hE7); add_stop();
    add_phase(1'b0); add_phase(1'b0);
    fork
      begin
        push(8'h96, 1'b0); push(8'h01, 1'b1); push(8'hE7, 1'b1);
      end
      capture(2, errs, first_bad, emp0, tmo);
    join
    check(!tmo && errs == 0, "R8 next start follows stop", errs, 0);

    // R10: buffer fills, ready drops, long message still sent as one frame
    configure(40);
    n_exp = 0;
    add_start();
    for (int b = 0; b < 12; b++) add_byte(8'h10 + 8'(b));
    add_stop();
    add_phase(1'b0); add_phase(1'b0);
    fork
      begin
        for (int b = 0; b < 8; b++) push(8'h10 + 8'(b), 1'b0);
        check(bready == 1'b0, "R10 ready low when full", bready, 0);
        for (int b = 8; b < 12; b++) push(8'h10 + 8'(b), b == 11);
      end
      capture(40, errs, first_bad, emp0, tmo);
    join
    check(!tmo && errs == 0, "R10 message longer than buffer", errs, 0);

    // R7: disable in the middle of a frame
    configure(3);
    push(8'hC3, 1'b0);
    push(8'h3C, 1'b1);
    bad = 0;
    while (trc !== 1'b1 && bad < 200) begin
      @(negedge clk);
      bad++;
    end
    repeat (12) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(trc == 1'b0, "R7 line low after disable", trc, 0);
    check(bready == 1'b0, "R7 ready low after disable", bready, 0);
    check(empty == 1'b1, "R7 buffer flushed on disable", empty, 1);
    divider = 16'd0; enable = 1'b1;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (trc !== 1'b0) bad++;
    end
    check(bad == 0, "R7 aborted frame not resumed", bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule